// File: doc/BRIEF.md
# FIFO Almost-Full / Almost-Empty Flag Unit

This block produces the two early-warning flags of a dual-clock FIFO. `pafN` is active low and warns that the FIFO is nearly full. `paeN` is active low and warns that it is nearly empty. The block does not keep its own count. It takes the FIFO's binary word pointers and computes occupancy as the write pointer minus the read pointer. Each pointer has two bits more than the address, so a first-word-fall-through FIFO can report the extra word that sits in its output register.

Two offsets set the thresholds: a full offset `m` and an empty offset `n`. Both load from parameters at master reset. They can be rewritten later, and read back, through a small parallel port clocked by the write clock. In fall-through mode both thresholds move up by one word, because the output register adds one word of storage.

The almost-full flag has two timing configurations. It can be a plain register on the write clock. It can also be a flag that a write-clock edge sets low and a read-clock edge returns high. While retransmit is active, the almost-full occupancy is taken from the marked location instead of the read pointer.

Top module: `fifoAlmostFlags`

## Requirements
- R1: In standard mode (`fwftMode`=0) with `asyncAf`=0, once settled, `pafN` is 0 exactly when occupancy (`wrPtr`-`rdPtr`, modulo 2^(ADDR_W+2)) is at least DEPTH-m, and 1 otherwise.
- R2: In fall-through mode (`fwftMode`=1), the almost-full threshold is DEPTH+1-m words.
- R3: In standard mode, once settled, `paeN` is 0 exactly when occupancy is n words or fewer.
- R4: In fall-through mode, `paeN` is 0 exactly when occupancy is n+1 words or fewer.
- R5: With `asyncAf`=1, a rising `wrClk` edge drives `pafN` low. A rising `rdClk` edge returns it high, and it does so even while `wrClk` is stopped.
- R6: With `asyncAf`=0, `pafN` changes only on `wrClk`. While `wrClk` is stopped it holds its value, even when the read pointer moves below the threshold.
- R7: While `rtActive`=1, the almost-full occupancy is `wrPtr`-`markPtr`. `paeN` keeps using `rdPtr`.
- R8: After master reset: m = DEF_FULL_OFS, n = DEF_EMPTY_OFS, `pafN`=1, and `paeN`=0 at zero occupancy.
- R9: A write with `cfgWe`=1 on a rising `wrClk` loads `cfgWdata` into m when `cfgSel`=0, or into n when `cfgSel`=1. `cfgRdata` returns the offset chosen by `cfgSel`, zero-extended.
- R10: A write whose `cfgWdata` is DEPTH or larger is ignored. The stored offset, as read back, keeps its old value.
- R11: A newly written offset is used by the next flag evaluation. The flags settle to the new thresholds without any other stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| rstN | input | 1 | Master reset, active low, asynchronous |
| fwftMode | input | 1 | 1 = first-word-fall-through thresholds |
| asyncAf | input | 1 | 1 = almost-full set by wrClk and cleared by rdClk |
| rtActive | input | 1 | 1 = retransmit, almost-full measured from markPtr |
| wrPtr | input | ADDR_W+2 | Binary write pointer (write domain) |
| rdPtr | input | ADDR_W+2 | Binary read pointer (read domain) |
| markPtr | input | ADDR_W+2 | Marked retransmit location, quasi-static |
| cfgWe | input | 1 | Offset write strobe (wrClk) |
| cfgSel | input | 1 | 0 = full offset m, 1 = empty offset n |
| cfgWdata | input | ADDR_W+2 | Offset value to write |
| cfgRdata | output | ADDR_W+2 | Selected offset, zero-extended |
| pafN | output | 1 | Almost-full flag, active low |
| paeN | output | 1 | Almost-empty flag, active low |

## Verification
A corrupted offset register shows up at `cfgRdata` at once. It also moves the flag thresholds by a fixed number of words, which the next settled comparison reveals. A broken pointer synchronizer or a wrong threshold term makes a flag settle on the wrong side of its boundary, within a few cycles of either clock. The bench therefore checks each boundary at occupancy one below and at the threshold. A faulty set/clear handshake shows up when the write clock is stopped: the almost-full flag then fails to return high, or returns high when it must hold. This is visible within a handful of read-clock cycles.

// File: rtl/fifoAlmostPkg.sv
package fifoAlmostPkg;

  // Offset-register load strobes from control to datapath.
  typedef struct packed {
    logic loadFull;
    logic loadEmpty;
  } ofsStrobe_t;

  // Threshold comparison results from datapath to control.
  typedef struct packed {
    logic fullHitW;    // write domain: occupancy at or above almost-full threshold
    logic fullClearR;  // read domain: occupancy below almost-full threshold
    logic emptyHitR;   // read domain: occupancy at or below almost-empty threshold
  } cmpResult_t;

endpackage

// File: rtl/fifoAlmostSync.sv
module fifoAlmostSync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/fifoAlmostDp.sv
module fifoAlmostDp
  import fifoAlmostPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_FULL    = 3,
  parameter int DEF_EMPTY   = 2
) (
  input  logic                wrClk,
  input  logic                rdClk,
  input  logic                rstN,
  input  logic                fwftMode,
  input  logic                rtActive,
  input  logic [ADDR_W+1:0]   wrPtr,
  input  logic [ADDR_W+1:0]   rdPtr,
  input  logic [ADDR_W+1:0]   markPtr,
  input  logic                cfgWe,
  input  logic                cfgSel,
  input  logic [ADDR_W+1:0]   cfgWdata,
  input  ofsStrobe_t          stb,
  output logic [ADDR_W+1:0]   cfgRdata,
  output cmpResult_t          res
);
  localparam int PTR_W = ADDR_W + 2;
  localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int k = PTR_W-2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  // Offset registers, loaded from defaults at master reset (R8)
  logic [ADDR_W-1:0] fullOfs, emptyOfs;

  always_ff @(posedge wrClk or negedge rstN)
    if (!rstN) begin
      fullOfs  <= ADDR_W'(DEF_FULL);
      emptyOfs <= ADDR_W'(DEF_EMPTY);
    end else begin
      if (stb.loadFull)  fullOfs  <= cfgWdata[ADDR_W-1:0];
      if (stb.loadEmpty) emptyOfs <= cfgWdata[ADDR_W-1:0];
    end

  assign cfgRdata = cfgSel ? PTR_W'(emptyOfs) : PTR_W'(fullOfs);

  // Pointer crossings in Gray code
  logic [PTR_W-1:0] wrGray, rdGray, wrGraySyncR, rdGraySyncW;

  always_ff @(posedge wrClk or negedge rstN)
    if (!rstN) wrGray <= '0;
    else       wrGray <= toGray(wrPtr);

  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN) rdGray <= '0;
    else       rdGray <= toGray(rdPtr);

  fifoAlmostSync #(.W(PTR_W), .STAGES(SYNC_STAGES)) i_wrToRd (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySyncR));
  fifoAlmostSync #(.W(PTR_W), .STAGES(SYNC_STAGES)) i_rdToWr (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySyncW));

  logic [PTR_W-1:0] wrPtrR, rdPtrW;
  assign wrPtrR = fromGray(wrGraySyncR);
  assign rdPtrW = fromGray(rdGraySyncW);

  // Mode-dependent thresholds (R1, R2, R3, R4)
  logic [PTR_W-1:0] fwftExt, fullThr, emptyThr;
  assign fwftExt  = PTR_W'(fwftMode);
  assign fullThr  = DEPTH_V + fwftExt - PTR_W'(fullOfs);
  assign emptyThr = PTR_W'(emptyOfs) + fwftExt;

  // Occupancy; almost-full is measured from the mark during retransmit (R7)
  logic [PTR_W-1:0] occFullW, occFullR, occEmptyR;
  assign occFullW  = wrPtr  - (rtActive ? markPtr : rdPtrW);
  assign occFullR  = wrPtrR - (rtActive ? markPtr : rdPtr);
  assign occEmptyR = wrPtrR - rdPtr;

  assign res.fullHitW   = occFullW >= fullThr;
  assign res.fullClearR = occFullR <  fullThr;
  assign res.emptyHitR  = occEmptyR <= emptyThr;

  // An out-of-range write leaves both offsets untouched (R10)
  p_keepOfs_r10: assert property (@(posedge wrClk) disable iff (!rstN)
    (cfgWe && cfgWdata >= DEPTH_V) |=> ($stable(fullOfs) && $stable(emptyOfs)));

  // A load strobe lands the written value (R9)
  p_loadOfs_r9: assert property (@(posedge wrClk) disable iff (!rstN)
    stb.loadFull |=> (fullOfs == $past(cfgWdata[ADDR_W-1:0])));

  // Full threshold stays within 1..DEPTH+1 words (R2)
  p_fullThrRange_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    (fullThr >= PTR_W'(1)) && (fullThr <= DEPTH_V + PTR_W'(1)));

  // Empty threshold never exceeds DEPTH words (R4)
  p_emptyThrRange_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyThr <= DEPTH_V);
endmodule

// File: rtl/fifoAlmostCtrl.sv
module fifoAlmostCtrl
  import fifoAlmostPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              asyncAf,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [ADDR_W+1:0] cfgWdata,
  input  cmpResult_t        res,
  output ofsStrobe_t        stb,
  output logic              pafN,
  output logic              paeN
);
  localparam int PTR_W = ADDR_W + 2;
  localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(1 << ADDR_W);

  // Offset write decode; out-of-range values are rejected (R9, R10)
  logic inRange;
  assign inRange       = cfgWdata < DEPTH_V;
  assign stb.loadFull  = cfgWe && !cfgSel && inRange;
  assign stb.loadEmpty = cfgWe &&  cfgSel && inRange;

  // Synchronous almost-full: evaluated on every write edge (R1, R6)
  logic pafSyncN;
  always_ff @(posedge wrClk or negedge rstN)
    if (!rstN) pafSyncN <= 1'b1;
    else       pafSyncN <= !res.fullHitW;

  // Asynchronous almost-full: set toggle on wrClk, clear toggle on rdClk (R5)
  logic setTgl, clrTgl, setSyncR, clrSyncW;

  fifoAlmostSync #(.W(1), .STAGES(SYNC_STAGES)) i_setToRd (
    .clk(rdClk), .rstN(rstN), .d(setTgl), .q(setSyncR));
  fifoAlmostSync #(.W(1), .STAGES(SYNC_STAGES)) i_clrToWr (
    .clk(wrClk), .rstN(rstN), .d(clrTgl), .q(clrSyncW));

  always_ff @(posedge wrClk or negedge rstN)
    if (!rstN)                                   setTgl <= 1'b0;
    else if (setTgl == clrSyncW && res.fullHitW) setTgl <= ~setTgl;

  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN)                                     clrTgl <= 1'b0;
    else if (setSyncR != clrTgl && res.fullClearR) clrTgl <= ~clrTgl;

  assign pafN = asyncAf ? ~(setTgl ^ clrTgl) : pafSyncN;

  // Almost-empty: read-domain register (R3, R4, R8)
  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN) paeN <= 1'b0;
    else       paeN <= !res.emptyHitR;

  // Write side only sets once the previous clear has arrived (R5)
  p_setAfterClear_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    !$stable(setTgl) |-> $past(setTgl == clrSyncW));

  // Read side only clears a set it has seen (R5)
  p_clearAfterSet_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    !$stable(clrTgl) |-> $past(setSyncR != clrTgl));
endmodule

// File: rtl/fifoAlmostFlags.sv
module fifoAlmostFlags
  import fifoAlmostPkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int DEF_FULL_OFS  = 3,
  parameter int DEF_EMPTY_OFS = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              fwftMode,
  input  logic              asyncAf,
  input  logic              rtActive,
  input  logic [ADDR_W+1:0] wrPtr,
  input  logic [ADDR_W+1:0] rdPtr,
  input  logic [ADDR_W+1:0] markPtr,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [ADDR_W+1:0] cfgWdata,
  output logic [ADDR_W+1:0] cfgRdata,
  output logic              pafN,
  output logic              paeN
);
  ofsStrobe_t stb;
  cmpResult_t res;

  fifoAlmostCtrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .asyncAf(asyncAf),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .res(res),
    .stb(stb), .pafN(pafN), .paeN(paeN));

  fifoAlmostDp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
                 .DEF_FULL(DEF_FULL_OFS), .DEF_EMPTY(DEF_EMPTY_OFS)) i_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .rtActive(rtActive), .wrPtr(wrPtr), .rdPtr(rdPtr), .markPtr(markPtr),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .stb(stb),
    .cfgRdata(cfgRdata), .res(res));
endmodule

// File: tb/test_fifoAlmostFlags.sv
module test_fifoAlmostFlags;
  localparam int ADDR_W = 4;
  localparam int PTR_W  = ADDR_W + 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DEF_M  = 3;
  localparam int DEF_N  = 2;

  logic wrClk = 1'b0, rdClk = 1'b0, wrRun = 1'b1;
  logic rstN = 1'b0, fwftMode = 1'b0, asyncAf = 1'b0, rtActive = 1'b0;
  logic [PTR_W-1:0] wrPtr = '0, rdPtr = '0, markPtr = '0, cfgWdata = '0;
  logic cfgWe = 1'b0, cfgSel = 1'b0;
  logic [PTR_W-1:0] cfgRdata;
  logic pafN, paeN;

  int total = 0, bad = 0;
  int mExp = DEF_M, nExp = DEF_N;
  bit done = 1'b0;

  always #10 if (wrRun) wrClk = ~wrClk;   // 50 MHz write clock
  always #7  rdClk = ~rdClk;

  fifoAlmostFlags #(.ADDR_W(ADDR_W), .DEF_FULL_OFS(DEF_M), .DEF_EMPTY_OFS(DEF_N))
    i_fifoAlmostFlags (
      .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
      .asyncAf(asyncAf), .rtActive(rtActive), .wrPtr(wrPtr), .rdPtr(rdPtr),
      .markPtr(markPtr), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
      .cfgRdata(cfgRdata), .pafN(pafN), .paeN(paeN));

  function automatic int expPaf(int occ, int m, bit fw);
    return (occ >= DEPTH + int'(fw) - m) ? 0 : 1;
  endfunction

  function automatic int expPae(int occ, int n, bit fw);
    return (occ <= n + int'(fw)) ? 0 : 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge wrClk);
  endtask

  task automatic setOcc(input int base, input int occ);
    @(negedge wrClk);
    rdPtr = PTR_W'(base);
    wrPtr = PTR_W'(base + occ);
  endtask

  task automatic wrOfs(input bit sel, input int val);
    @(negedge wrClk);
    cfgSel = sel; cfgWdata = PTR_W'(val); cfgWe = 1'b1;
    @(negedge wrClk);
    cfgWe = 1'b0;
    if (val < DEPTH) begin
      if (sel) nExp = val; else mExp = val;
    end
  endtask

  task automatic readOfs(input bit sel, output int val);
    cfgSel = sel;
    #1 val = int'(cfgRdata);
  endtask

  task automatic stopWr();
    @(negedge wrClk);
    #1 wrRun = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge wrClk);
    rstN = 1'b1;
    settle();

    // R8: reset state
    chk("R8 pafN", pafN, 1);
    chk("R8 paeN", paeN, 0);
    readOfs(1'b0, v); chk("R8 m default", v, DEF_M);
    readOfs(1'b1, v); chk("R8 n default", v, DEF_N);

    // R1 / R3: standard thresholds, wrapped base
    setOcc(58, DEPTH - DEF_M - 1); settle(); chk("R1 below", pafN, 1);
    setOcc(60, DEPTH - DEF_M);     settle(); chk("R1 at", pafN, 0);
    setOcc(5, DEF_N);              settle(); chk("R3 at", paeN, 0);
    setOcc(5, DEF_N + 1);          settle(); chk("R3 above", paeN, 1);

    // R2 / R4: fall-through shifts both by one
    fwftMode = 1'b1;
    setOcc(40, DEPTH - DEF_M);     settle(); chk("R2 below", pafN, 1);
    setOcc(40, DEPTH + 1 - DEF_M); settle(); chk("R2 at", pafN, 0);
    setOcc(9, DEF_N + 1);          settle(); chk("R4 at", paeN, 0);
    setOcc(9, DEF_N + 2);          settle(); chk("R4 above", paeN, 1);
    setOcc(9, DEPTH + 1);          settle(); chk("R2 full+1", pafN, 0);
    fwftMode = 1'b0;

    // R9 / R11: reprogram and observe new thresholds
    setOcc(20, 11); settle(); chk("R11 before m", pafN, 1);
    wrOfs(1'b0, 5); readOfs(1'b0, v); chk("R9 m readback", v, 5);
    settle(); chk("R11 after m", pafN, 0);
    setOcc(20, 4); settle(); chk("R11 before n", paeN, 1);
    wrOfs(1'b1, 4); readOfs(1'b1, v); chk("R9 n readback", v, 4);
    settle(); chk("R11 after n", paeN, 0);

    // R10: out-of-range writes ignored
    wrOfs(1'b0, DEPTH);     readOfs(1'b0, v); chk("R10 m kept", v, 5);
    wrOfs(1'b1, DEPTH + 4); readOfs(1'b1, v); chk("R10 n kept", v, 4);
    setOcc(20, 11); settle(); chk("R10 flag kept", pafN, 0);

    // R7: retransmit measures from the mark
    setOcc(30, 8); settle(); chk("R7 normal", pafN, 1);
    markPtr = PTR_W'(30 - 4); rtActive = 1'b1;
    settle(); chk("R7 marked", pafN, 0);
    chk("R7 pae from rdPtr", paeN, expPae(8, nExp, 1'b0));
    rtActive = 1'b0; settle(); chk("R7 released", pafN, 1);

    // R5: async flag cleared by rdClk alone
    asyncAf = 1'b1;
    setOcc(10, 12); settle(); chk("R5 set low", pafN, 0);
    stopWr();
    #2 rdPtr = PTR_W'(14);
    #200 chk("R5 clear on rdClk", pafN, 1);
    wrRun = 1'b1; settle();
    chk("R5 stays clear", pafN, 1);

    // R6: sync flag holds while wrClk is stopped
    asyncAf = 1'b0;
    setOcc(10, 12); settle(); chk("R6 set low", pafN, 0);
    stopWr();
    #2 rdPtr = PTR_W'(14);
    #200 chk("R6 held", pafN, 0);
    wrRun = 1'b1; settle();
    chk("R6 after restart", pafN, 1);

    // Random mix (R1..R4, R9, R10, R5)
    for (int it = 0; it < 60; it++) begin
      bit fw = 1'($urandom_range(0, 1));
      bit sel = 1'($urandom_range(0, 1));
      int val = $urandom_range(0, DEPTH + 3);
      int occ = $urandom_range(0, DEPTH + int'(fw));
      int base = $urandom_range(0, (1 << PTR_W) - 1);
      asyncAf = 1'($urandom_range(0, 1));
      fwftMode = fw;
      wrOfs(sel, val);
      setOcc(base, occ);
      settle();
      chk(fw ? "R2 rand paf" : "R1 rand paf", pafN, expPaf(occ, mExp, fw));
      chk(fw ? "R4 rand pae" : "R3 rand pae", paeN, expPae(occ, nExp, fw));
      readOfs(sel, v);
      chk("R10 rand readback", v, sel ? nExp : mExp);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule